// File: doc/BRIEF.md
# SPI Master Controller

This block is a register-mapped SPI master. Software programs a small register file: a control register that picks one of eight chip selects and asserts it, and a configuration register that holds clock polarity and phase, word size (8 or 16 bits), and separate first-bit order for the transmit and receive directions. A write to the transmit data register starts one full-duplex word exchange. The shift engine then moves one SCK half-period for each pulse on `sck_tick`. That pulse comes from an external rate divider, whose settings the block stores and passes out on `clk_cfg`.

The engine samples MISO a programmable number of core cycles after each sampling SCK edge. This lets a board with long return paths move the capture point later. When the last bit has been captured, the engine loads the received word into the receive data register and sets a completion flag. Software polls the flag and clears it by writing zero. A busy bit in the control register reports an exchange in progress. A transmit write made while busy is dropped.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, control reads 0x0000, configuration 0x0000, timing 0x0040 (sample delay 1), completion 0 and receive 0. All chip-select lines are high, SCK is low and `clk_cfg` is 0.
- R2: Line `spi_cs_n[i]` is low exactly when control bit 0 is 1 and control bits 4:2 equal i. Every other line is high.
- R3: Outside an exchange, SCK equals configuration bit 11 (polarity). During an exchange, SCK toggles once per accepted `sck_tick`, making exactly 2N transitions for an N-bit word.
- R4: With configuration bit 12 (phase) clear, MISO and MOSI are sampled on SCK transitions 1, 3, 5… and MOSI moves on the even ones. With the bit set, sampling happens on transitions 2, 4, 6… and MOSI moves on the odd ones.
- R5: Configuration bit 5 set selects 16-bit words and clear selects 8-bit words. In 8-bit mode only bits 7:0 of the transmit write are sent.
- R6: Configuration bit 13 sends the transmit word least significant bit first. Configuration bit 14 stores the first received bit in bit 0 instead of bit N-1. The two bits act independently.
- R7: A write to offset 0x08 while idle starts an exchange. Control bit 1 (busy) reads 1 from the next cycle until completion.
- R8: A transmit write during an exchange has no effect. The ongoing word is sent unchanged and no second exchange follows.
- R9: The completion flag (offset 0x10, bit 0) reads 1 in the cycle busy falls. This is d+1 cycles after the final SCK transition with phase set, and 1 cycle after it with phase clear. Writing a value with bit 0 clear clears the flag. Writing bit 0 set leaves it unchanged.
- R10: Offset 0x0C returns the word received in the last completed exchange. It updates only at completion.
- R11: Timing bits 7:6 hold the sample delay d (0 to 3). MISO is captured d core cycles after the sampling SCK edge, where d=0 means the clock edge that moves SCK.
- R12: Configuration bits 7:6 and 4:0 are stored and driven on `clk_cfg` as {bits 7:6, bits 4:0}. Configuration reads back only implemented bits (mask 0x78FF).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| sck_tick | input | 1 | One-cycle pulse per SCK half-period from the rate divider |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 8 | Active-low chip selects |
| clk_cfg | output | 7 | Stored rate-divider settings |

## Verification
Register writes take effect at the clock edge that accepts them, so the bench samples chip selects, `clk_cfg` and the busy bit at the next falling edge. SCK and MOSI move at the edge that accepts a tick. The bench's slave model notes each transition half a cycle later and moves its MISO bit one and a half cycles after a sampling edge. As a result, delays 0 and 1 capture the intended bit, and delays 2 and 3 capture the next one. The completion flag is polled every falling edge, and the gap from the final SCK transition is compared with d+1 for phase set and 1 for phase clear.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int ADDR_W     = 5;
  localparam int WORD_LONG  = 16;
  localparam int WORD_SHORT = 8;
  localparam int CNT_W      = $clog2(WORD_LONG + 1);
  localparam int EDGE_W     = CNT_W + 1;
  localparam int POS_W      = $clog2(WORD_LONG);
  localparam int DLY_W      = 2;
  localparam int DLY_TAPS   = (1 << DLY_W) - 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_TX    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_RX    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_TIME  = 5'h18;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_BUSY   = 1;
  localparam int CTRL_IDX_LO = 2;
  localparam int CFG_WIDE    = 5;
  localparam int CFG_CPOL    = 11;
  localparam int CFG_CPHA    = 12;
  localparam int CFG_TXLSB   = 13;
  localparam int CFG_RXLSB   = 14;
  localparam int TIME_SEL_LO = 6;
  localparam logic [15:0] CFG_MASK = 16'h78FF;
  localparam logic [DLY_W-1:0] SEL_RESET = 2'd1;

  typedef struct packed {
    logic rx_lsb;
    logic tx_lsb;
    logic cpha;
    logic cpol;
    logic wide;
  } spim_mode_t;

  // Number of bits in a word for the chosen size.
  function automatic logic [CNT_W-1:0] word_bits(input logic wide);
    return wide ? CNT_W'(WORD_LONG) : CNT_W'(WORD_SHORT);
  endfunction

  // Register bit that holds time slot pos, for the given order.
  function automatic logic [POS_W-1:0] bit_slot(input logic [POS_W-1:0] pos,
                                                input logic wide,
                                                input logic lsb_first);
    logic [POS_W-1:0] top_i;
    top_i = wide ? POS_W'(WORD_LONG - 1) : POS_W'(WORD_SHORT - 1);
    return lsb_first ? pos : top_i - pos;
  endfunction

  // k is the transition count after the edge (1-based).
  function automatic logic is_sample_edge(input logic [EDGE_W-1:0] k,
                                          input logic cpha);
    return k[0] ^ cpha;
  endfunction
endpackage

// File: rtl/spim_regs.sv
`timescale 1ns/1ps
module spim_regs import spim_pkg::*; #(
  parameter int DW     = 16,
  parameter int IDX_W  = 3,
  parameter int WORD_W = WORD_LONG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              busy,
  input  logic              done_evt,
  input  logic [WORD_W-1:0] rx_word,
  output logic              start_evt,
  output logic [WORD_W-1:0] tx_word,
  output spim_mode_t        mode,
  output logic [6:0]        clk_cfg,
  output logic              cs_en,
  output logic [IDX_W-1:0]  cs_idx,
  output logic [DLY_W-1:0]  samp_sel,
  output logic              cause
);
  logic [15:0]       cfg_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  logic              en_q, cause_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DLY_W-1:0]  sel_q;

  logic wr_ctrl, wr_cfg, wr_tx, wr_cause, wr_time;
  assign wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);
  assign wr_cfg   = reg_we && (reg_addr == OFS_CFG);
  assign wr_tx    = reg_we && (reg_addr == OFS_TX);
  assign wr_cause = reg_we && (reg_addr == OFS_CAUSE);
  assign wr_time  = reg_we && (reg_addr == OFS_TIME);

  assign start_evt = wr_tx && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      en_q    <= 1'b0;
      idx_q   <= '0;
      sel_q   <= SEL_RESET;
      cause_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= reg_wdata[CTRL_EN];
        idx_q <= reg_wdata[CTRL_IDX_LO +: IDX_W];
      end
      if (wr_cfg)  cfg_q <= reg_wdata[15:0] & CFG_MASK;
      if (wr_time) sel_q <= reg_wdata[TIME_SEL_LO +: DLY_W];
      if (start_evt) begin
        if (cfg_q[CFG_WIDE]) tx_q <= reg_wdata[WORD_W-1:0];
        else                 tx_q <= {{(WORD_W-WORD_SHORT){1'b0}}, reg_wdata[WORD_SHORT-1:0]};
      end
      if (done_evt) begin
        rx_q    <= rx_word;
        cause_q <= 1'b1;
      end else if (wr_cause && !reg_wdata[0]) begin
        cause_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CTRL_EN]               = en_q;
        reg_rdata[CTRL_BUSY]             = busy;
        reg_rdata[CTRL_IDX_LO +: IDX_W]  = idx_q;
      end
      OFS_CFG:   reg_rdata[15:0]                    = cfg_q;
      OFS_RX:    reg_rdata[WORD_W-1:0]              = rx_q;
      OFS_CAUSE: reg_rdata[0]                       = cause_q;
      OFS_TIME:  reg_rdata[TIME_SEL_LO +: DLY_W]    = sel_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign tx_word     = tx_q;
  assign mode.wide   = cfg_q[CFG_WIDE];
  assign mode.cpol   = cfg_q[CFG_CPOL];
  assign mode.cpha   = cfg_q[CFG_CPHA];
  assign mode.tx_lsb = cfg_q[CFG_TXLSB];
  assign mode.rx_lsb = cfg_q[CFG_RXLSB];
  assign clk_cfg     = {cfg_q[7:6], cfg_q[4:0]};
  assign cs_en       = en_q;
  assign cs_idx      = idx_q;
  assign samp_sel    = sel_q;
  assign cause       = cause_q;
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift import spim_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_evt,
  input  logic [WORD_LONG-1:0] tx_word,
  input  spim_mode_t           mode,
  input  logic [DLY_W-1:0]     samp_sel,
  input  logic                 tick,
  input  logic                 miso,
  output logic                 busy,
  output logic                 done_evt,
  output logic                 sample_evt,
  output logic                 capture_evt,
  output logic                 phase_odd,
  output logic                 mosi,
  output logic [WORD_LONG-1:0] rx_word
);
  logic                 busy_q, wide_q, cpha_q, txl_q, rxl_q;
  logic [DLY_W-1:0]     sel_q;
  logic [EDGE_W-1:0]    edge_q;
  logic [CNT_W-1:0]     cap_q;
  logic [DLY_TAPS-1:0]  dly_q;
  logic [WORD_LONG-1:0] acc_q;

  logic [CNT_W-1:0]  nbits;
  logic [EDGE_W-1:0] last_edge, edge_nxt, pos6, nb6;
  logic [POS_W-1:0]  pos_c, nb_m1;
  logic              tick_ok;

  assign nbits     = word_bits(wide_q);
  assign last_edge = {nbits, 1'b0};
  assign nb6       = {1'b0, nbits};
  assign nb_m1     = wide_q ? POS_W'(WORD_LONG - 1) : POS_W'(WORD_SHORT - 1);
  assign edge_nxt  = edge_q + 1'b1;
  assign tick_ok   = busy_q && tick && (edge_q != last_edge);

  assign sample_evt = tick_ok && is_sample_edge(edge_nxt, cpha_q);
  assign done_evt   = busy_q && (edge_q == last_edge) && (cap_q == nbits);

  // Capture strobe: sampling edge delayed by sel_q core cycles.
  always_comb begin
    capture_evt = sample_evt;
    for (int t = 1; t <= DLY_TAPS; t++)
      if (sel_q == DLY_W'(t)) capture_evt = dly_q[t-1];
  end

  // Transmit time slot currently on the wire.
  assign pos6  = (cpha_q && edge_q != '0) ? (edge_q - 1'b1) >> 1 : edge_q >> 1;
  assign pos_c = (pos6 >= nb6) ? nb_m1 : pos6[POS_W-1:0];
  assign mosi  = busy_q ? tx_word[bit_slot(pos_c, wide_q, txl_q)] : 1'b0;

  generate
    if (DLY_TAPS > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dly_q <= '0;
        else if (start_evt) dly_q <= '0;
        else                dly_q <= {dly_q[DLY_TAPS-2:0], sample_evt};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dly_q <= '0;
        else if (start_evt) dly_q <= '0;
        else                dly_q <= sample_evt;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wide_q <= 1'b0;
      cpha_q <= 1'b0;
      txl_q  <= 1'b0;
      rxl_q  <= 1'b0;
      sel_q  <= SEL_RESET;
      edge_q <= '0;
      cap_q  <= '0;
      acc_q  <= '0;
    end else if (start_evt) begin
      busy_q <= 1'b1;
      wide_q <= mode.wide;
      cpha_q <= mode.cpha;
      txl_q  <= mode.tx_lsb;
      rxl_q  <= mode.rx_lsb;
      sel_q  <= samp_sel;
      edge_q <= '0;
      cap_q  <= '0;
      acc_q  <= '0;
    end else if (done_evt) begin
      busy_q <= 1'b0;
      edge_q <= '0;
    end else begin
      if (tick_ok) edge_q <= edge_nxt;
      if (capture_evt && busy_q && cap_q != nbits) begin
        acc_q[bit_slot(cap_q[POS_W-1:0], wide_q, rxl_q)] <= miso;
        cap_q <= cap_q + 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign phase_odd = edge_q[0];
  assign rx_word   = acc_q;
endmodule

// File: rtl/spim_csel.sv
`timescale 1ns/1ps
module spim_csel #(
  parameter int NUM_CS = 8,
  parameter int IDX_W  = $clog2(NUM_CS)
) (
  input  logic             cs_en,
  input  logic [IDX_W-1:0] cs_idx,
  output logic [NUM_CS-1:0] cs_n
);
  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
      assign cs_n[i] = !(cs_en && (cs_idx == MY_IDX));
    end
  endgenerate
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl import spim_pkg::*; #(
  parameter int DW     = 16,
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              sck_tick,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic [6:0]        clk_cfg
);
  localparam int IDX_W = $clog2(NUM_CS);

  spim_mode_t           mode;
  logic [WORD_LONG-1:0] tx_word, rx_word;
  logic                 busy, done_evt, start_evt, sample_evt, capture_evt;
  logic                 phase_odd, cs_en, cause, cpol;
  logic [IDX_W-1:0]     cs_idx;
  logic [DLY_W-1:0]     samp_sel;

  spim_regs #(.DW(DW), .IDX_W(IDX_W), .WORD_W(WORD_LONG)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .done_evt(done_evt), .rx_word(rx_word), .start_evt(start_evt),
    .tx_word(tx_word), .mode(mode), .clk_cfg(clk_cfg), .cs_en(cs_en),
    .cs_idx(cs_idx), .samp_sel(samp_sel), .cause(cause)
  );

  spim_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .tx_word(tx_word),
    .mode(mode), .samp_sel(samp_sel), .tick(sck_tick), .miso(spi_miso),
    .busy(busy), .done_evt(done_evt), .sample_evt(sample_evt),
    .capture_evt(capture_evt), .phase_odd(phase_odd), .mosi(spi_mosi),
    .rx_word(rx_word)
  );

  spim_csel #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_csel (
    .cs_en(cs_en), .cs_idx(cs_idx), .cs_n(spi_cs_n)
  );

  assign cpol    = mode.cpol;
  assign spi_sck = cpol ^ phase_odd;
endmodule

// File: rtl/spim_ctrl_chk.sv
`timescale 1ns/1ps
module spim_ctrl_chk #(
  parameter int NUM_CS = 8,
  parameter int WW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done_evt,
  input logic              start_evt,
  input logic              capture_evt,
  input logic              sck_tick,
  input logic              spi_sck,
  input logic              cpol,
  input logic              cause,
  input logic [WW-1:0]     tx_word,
  input logic [NUM_CS-1:0] spi_cs_n
);
  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~spi_cs_n) <= 1); // R2
  AST_SCK_IDLE_POL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sck == cpol)); // R3
  AST_SCK_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sck_tick) |=> $stable(spi_sck)); // R3
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy); // R7
  AST_TX_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tx_word)); // R8
  AST_DONE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (cause && !busy)); // R9
  AST_CAPTURE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> busy); // R11
endmodule

bind spim_ctrl spim_ctrl_chk #(.NUM_CS(NUM_CS), .WW(spim_pkg::WORD_LONG)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done_evt(done_evt),
  .start_evt(start_evt), .capture_evt(capture_evt), .sck_tick(sck_tick),
  .spi_sck(spi_sck), .cpol(cpol), .cause(cause), .tx_word(tx_word),
  .spi_cs_n(spi_cs_n)
);

// File: tb/test_spim_ctrl.sv
`timescale 1ns/1ps
module test_spim_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        sck_tick = 1'b0;
  logic        spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic [7:0]  spi_cs_n;
  logic [6:0]  clk_cfg;

  int vectors = 0;
  int errors  = 0;
  longint cyc = 0;
  bit finished = 1'b0;

  // slave model state
  int          sl_bit = 0, sl_edges = 0, sl_n = 8;
  bit          sl_cpha = 1'b0, adv_due = 1'b0, last_sck = 1'b0;
  logic [15:0] sl_word = '0, sl_got = '0;
  longint      last_edge_cyc = 0;

  spim_ctrl i_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_tick(sck_tick),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .clk_cfg(clk_cfg)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // free-running half-period pulse, one every 6 cycles
  initial forever begin
    @(negedge clk);
    sck_tick = (cyc % 6 == 0);
  end

  // slave: moves MISO 1.5 cycles after each sampling edge
  initial forever begin
    @(negedge clk);
    if (adv_due) begin
      sl_bit  = sl_bit + 1;
      adv_due = 1'b0;
    end
    if (spi_sck !== last_sck) begin
      sl_edges      = sl_edges + 1;
      last_edge_cyc = cyc;
      if (((sl_edges % 2) == 1) != sl_cpha) begin
        sl_got  = {sl_got[14:0], spi_mosi};
        adv_due = 1'b1;
      end
    end
    last_sck = spi_sck;
    spi_miso = (sl_bit < sl_n) ? sl_word[sl_n-1-sl_bit] : 1'b0;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] rev(input logic [15:0] v, input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[n-1-i] = v[i];
    return r;
  endfunction

  function automatic logic [15:0] msk(input logic [15:0] v, input int n);
    return (n == 16) ? v : (v & 16'h00FF);
  endfunction

  task automatic xfer(input bit cpol, input bit cpha, input bit wide, input bit txl,
                      input bit rxl, input int sel, input logic [15:0] tx,
                      input logic [15:0] sw, input bit dup, input int csi);
    logic [15:0] v, exp_mo, exp_rx, stream;
    longint done_cyc;
    int n, edges_at_done, guard;
    n = wide ? 16 : 8;
    wr(5'h04, 16'(cpol) << 11 | 16'(cpha) << 12 | 16'(wide) << 5 |
              16'(txl) << 13 | 16'(rxl) << 14 | 16'h0043);
    wr(5'h18, 16'(sel) << 6);
    wr(5'h00, 16'(csi) << 2 | 16'h1);
    repeat (2) @(negedge clk);
    check(spi_sck == cpol, "R3 idle sck", spi_sck, cpol);
    check(spi_cs_n == ~(8'h1 << csi), "R2 cs in xfer", spi_cs_n, ~(8'h1 << csi));
    sl_n = n; sl_cpha = cpha; sl_word = msk(sw, n); sl_got = '0;
    sl_bit = 0; sl_edges = 0; adv_due = 1'b0;
    repeat (2) @(negedge clk);
    wr(5'h08, tx);
    rd(5'h00, v);
    check(v[1] == 1'b1, "R7 busy after start", v, 16'h2);
    if (dup) begin
      repeat (20) @(negedge clk);
      wr(5'h08, ~tx);
    end
    guard = 0;
    do begin
      rd(5'h10, v);
      guard++;
    end while (!v[0] && guard < 2000);
    done_cyc = cyc;
    edges_at_done = sl_edges;
    check(edges_at_done == 2 * n, "R3 sck transitions", edges_at_done, 2 * n);
    check(done_cyc - last_edge_cyc == (cpha ? sel + 1 : 1), "R9 cause timing",
          32'(done_cyc - last_edge_cyc), cpha ? sel + 1 : 1);
    rd(5'h00, v);
    check(v[1] == 1'b0, "R7 busy cleared", v, 16'h0);
    exp_mo = txl ? rev(msk(tx, n), n) : msk(tx, n);
    check(sl_got == exp_mo, "R4/R5/R6 mosi word", sl_got, exp_mo);
    stream = (sel >= 2) ? msk(sl_word << 1, n) : sl_word;
    exp_rx = rxl ? rev(stream, n) : stream;
    rd(5'h0C, v);
    check(v == exp_rx, "R10/R11 rx word", v, exp_rx);
    wr(5'h10, 16'h0001);
    rd(5'h10, v);
    check(v[0] == 1'b1, "R9 write one keeps", v, 16'h1);
    wr(5'h10, 16'h0000);
    rd(5'h10, v);
    check(v[0] == 1'b0, "R9 write zero clears", v, 16'h0);
    if (dup) begin
      repeat (100) @(negedge clk);
      check(sl_edges == edges_at_done, "R8 no second exchange", sl_edges, edges_at_done);
      rd(5'h0C, v);
      check(v == exp_rx, "R8 rx unchanged", v, exp_rx);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, v); check(v == 16'h0000, "R1 ctrl", v, 16'h0);
    rd(5'h04, v); check(v == 16'h0000, "R1 cfg", v, 16'h0);
    rd(5'h18, v); check(v == 16'h0040, "R1 timing", v, 16'h40);
    rd(5'h10, v); check(v == 16'h0000, "R1 cause", v, 16'h0);
    rd(5'h0C, v); check(v == 16'h0000, "R1 rx", v, 16'h0);
    check(spi_cs_n == 8'hFF, "R1 cs", spi_cs_n, 8'hFF);
    check(spi_sck == 1'b0, "R1 sck", spi_sck, 0);
    check(clk_cfg == 7'h0, "R1 clk_cfg", clk_cfg, 0);

    // R2 chip-select sweep
    for (int en = 0; en < 2; en++)
      for (int ix = 0; ix < 8; ix++) begin
        wr(5'h00, 16'(ix << 2 | en));
        check(spi_cs_n == (en ? ~(8'h1 << ix) : 8'hFF), "R2 cs decode",
              spi_cs_n, en ? ~(8'h1 << ix) : 8'hFF);
      end

    // R12 stored divider settings and readback mask
    for (int k = 0; k < 4; k++) begin
      logic [15:0] p;
      p = 16'hFFFF ^ 16'(k * 16'h2D4B);
      p[12:11] = 2'b00;
      wr(5'h04, p);
      check(clk_cfg == {p[7:6], p[4:0]}, "R12 clk_cfg", clk_cfg, {p[7:6], p[4:0]});
      rd(5'h04, v);
      check(v == (p & 16'h78FF), "R12 cfg readback", v, p & 16'h78FF);
    end
    wr(5'h04, 16'h0000);

    // R4 R5 R6: all modes, sizes and orders at default delay
    for (int k = 0; k < 32; k++)
      xfer(k[0], k[1], k[2], k[3], k[4], 1,
           16'hA5C3 ^ 16'(k * 16'h1357), 16'h3C96 ^ 16'(k * 16'h0F31), 1'b0, k % 8);

    // R11 sample delay sweep, both phases
    for (int s = 0; s < 4; s++)
      for (int ph = 0; ph < 2; ph++)
        xfer(ph[0], ph[0], 1'b1, 1'b0, 1'b0, s,
             16'h9B2E ^ 16'(s * 16'h0707), 16'hD14A ^ 16'(s * 16'h1111 + ph), 1'b0, s);

    // R8 transmit write during an exchange
    xfer(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1, 16'h005A, 16'h00C3, 1'b1, 3);
    xfer(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1, 16'hF00D, 16'h1234, 1'b1, 6);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule